// File: doc/BRIEF.md
# Strobed Serial Control-Register Loader

This block receives control words from a host over three slow pins: a data line, a frame-enable line that is active low, and a strobe. It brings all three pins into the system clock domain. While the frame-enable line is low, it shifts one data bit in on each rising strobe edge, most significant bit first. When the frame-enable line returns high after exactly sixteen bits, the word is not used at once. The block waits for four more rising strobe edges and only then treats the word as committed.

A committed word names one of four 16-bit control registers in its bits 2:1. Bit 0 is reserved and must be zero. A word with bit 0 set is dropped. Consumers read the registers once per fixed update interval, nominally 125 µs, so register updates are spaced at least that far apart. A commit that arrives inside the interval waits in a per-register pending slot. A newer commit to the same register overwrites that slot. Pending updates are applied one per interval, lowest register index first. Each applied update raises a one-cycle pulse on the flag of the register it changed.

Top module: `strobe_ctl_loader`

## Requirements
- R1: After reset all four registers read zero and no update flag is raised.
- R2: While the frame-enable line is low, data is sampled on each rising strobe edge. The first bit sampled becomes bit 15 of the word and the sixteenth becomes bit 0.
- R3: A word is committed only on the fourth rising strobe edge after the frame-enable line has returned high. With three edges or fewer, nothing changes. The strobe has no minimum rate, so a fourth edge that comes much later still commits the word.
- R4: Word bits 2:1 select register 0, 1, 2 or 3. Each update changes exactly that register, raises only its flag (bit i of `upd_o` for register i), and does so for one cycle.
- R5: A committed word with bit 0 equal to 1 changes no register and raises no flag.
- R6: A frame that ends with a bit count other than sixteen is discarded, even if four extra strobe edges follow it.
- R7: Two applied updates are never less than HOLDOFF_CYC clock cycles apart.
- R8: A commit that falls inside the hold-off interval is applied when the interval expires. A later commit to the same register replaces the waiting value. When several registers are waiting, the lowest index is applied first, one per interval.
- R9: A frame whose strobe runs at a very slow rate (tens of clock cycles per phase) is received exactly like a fast one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_strobe_i | input | 1 | Serial strobe pin, asynchronous |
| ctl_drdy_i | input | 1 | Frame-enable pin, low during the data phase, asynchronous |
| ctl_data_i | input | 1 | Serial data pin, asynchronous |
| regs_o | output | NUM_REGS*WORD_W (64) | Register contents; register i sits at bits [16*i+15:16*i] |
| upd_o | output | NUM_REGS (4) | One-cycle update flag per register |

## Verification
A wrong bit counter or a wrong shift direction shows up in the first committed frame as a wrong value on `regs_o`. A wrong extra-pulse count appears as an update raised one strobe early or late, or not raised at all. Faults in the hold-off logic only show when commits arrive close together. They appear as two flags spaced closer than the interval, as a stale pending value overwriting a newer one, or as registers applied out of index order. The bench therefore packs three commits into one interval and measures the spacing between every pair of flags.

// File: rtl/ctl_loader_pkg.sv
package ctl_loader_pkg;

  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_SHIFT = 2'd1,
    FR_TAIL  = 2'd2
  } frame_st_t;

endpackage

// File: rtl/ctl_pin_sync.sv
module ctl_pin_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [WIDTH-1:0] q;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q <= RST_VAL;
          else        q <= g_stage[g-1].q;
        end
      end
    end
  endgenerate

  assign sync_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx
  import ctl_loader_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int EXTRA_PULSES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_s,
  input  logic              drdy_s,
  input  logic              data_s,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);

  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam int XW    = $clog2(EXTRA_PULSES + 1);
  localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] BITS_OVER = CNT_W'(WORD_W + 1);
  localparam logic [XW-1:0]    XTRA_LAST = XW'(EXTRA_PULSES - 1);

  frame_st_t          st_q, st_d;
  logic               strobe_d_q;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [CNT_W-1:0]   bits_q, bits_d;
  logic [XW-1:0]      xtra_q, xtra_d;
  logic               commit_q, commit_d;
  logic               rise;

  assign rise = strobe_s & ~strobe_d_q;

  always_comb begin
    st_d     = st_q;
    sh_d     = sh_q;
    bits_d   = bits_q;
    xtra_d   = xtra_q;
    commit_d = 1'b0;
    case (st_q)
      FR_IDLE: begin
        if (!drdy_s) begin
          st_d   = FR_SHIFT;
          bits_d = '0;
        end
      end
      FR_SHIFT: begin
        if (drdy_s) begin
          if (bits_q == BITS_FULL) begin
            st_d   = FR_TAIL;
            xtra_d = '0;
          end else begin
            st_d = FR_IDLE;
          end
        end else if (rise) begin
          sh_d = {sh_q[WORD_W-2:0], data_s};
          if (bits_q != BITS_OVER) bits_d = bits_q + 1'b1;
        end
      end
      FR_TAIL: begin
        if (!drdy_s) begin
          st_d   = FR_SHIFT;
          bits_d = '0;
        end else if (rise) begin
          if (xtra_q == XTRA_LAST) begin
            commit_d = 1'b1;
            st_d     = FR_IDLE;
          end else begin
            xtra_d = xtra_q + 1'b1;
          end
        end
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FR_IDLE;
      strobe_d_q <= 1'b0;
      sh_q       <= '0;
      bits_q     <= '0;
      xtra_q     <= '0;
      commit_q   <= 1'b0;
    end else begin
      st_q       <= st_d;
      strobe_d_q <= strobe_s;
      sh_q       <= sh_d;
      bits_q     <= bits_d;
      xtra_q     <= xtra_d;
      commit_q   <= commit_d;
    end
  end

  assign word_o   = sh_q;
  assign commit_o = commit_q;

  // R3: a commit is only issued out of the tail phase
  a_r3_commit_from_tail: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(st_q == FR_TAIL));

  // R6: a committed frame carried exactly WORD_W bits
  a_r6_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> (bits_q == BITS_FULL));

  // R2: an edge detection never lasts two cycles
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ctl_update_gate.sv
module ctl_update_gate #(
  parameter int WORD_W      = 16,
  parameter int NUM_REGS    = 4,
  parameter int ADDR_LSB    = 1,
  parameter int HOLDOFF_CYC = 15625
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       commit_i,
  input  logic [WORD_W-1:0]          word_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        upd_o
);

  localparam int AW = $clog2(NUM_REGS);
  localparam int HW = $clog2(HOLDOFF_CYC + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLDOFF_CYC - 1);
  localparam logic [HW-1:0] HOLD_FULL = HW'(HOLDOFF_CYC);

  logic [NUM_REGS-1:0][WORD_W-1:0] regs_q, regs_d;
  logic [NUM_REGS-1:0][WORD_W-1:0] pval_q, pval_d;
  logic [NUM_REGS-1:0]             pend_q, pend_d;
  logic [NUM_REGS-1:0]             upd_q, upd_d;
  logic [HW-1:0]                   hold_q, hold_d;
  logic [AW-1:0]                   sel, addr;
  logic                            accept, fire;

  assign accept = commit_i & ~word_i[0];
  assign addr   = word_i[ADDR_LSB +: AW];
  assign fire   = (hold_q == '0) & (|pend_q);

  always_comb begin
    sel = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = AW'(i);
    end
  end

  always_comb begin
    regs_d = regs_q;
    pval_d = pval_q;
    pend_d = pend_q;
    upd_d  = '0;
    hold_d = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
    if (fire) begin
      regs_d[sel] = pval_q[sel];
      upd_d[sel]  = 1'b1;
      pend_d[sel] = 1'b0;
      hold_d      = HOLD_LOAD;
    end
    if (accept) begin
      pend_d[addr] = 1'b1;
      pval_d[addr] = word_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
      pval_q <= '0;
      pend_q <= '0;
      upd_q  <= '0;
      hold_q <= '0;
    end else begin
      regs_q <= regs_d;
      pval_q <= pval_d;
      pend_q <= pend_d;
      upd_q  <= upd_d;
      hold_q <= hold_d;
    end
  end

  assign regs_o = regs_q;
  assign upd_o  = upd_q;

  // Checker counter: cycles since the last applied update, saturating
  logic [HW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_q <= HOLD_FULL;
    else if (|upd_q)            gap_q <= HW'(1);
    else if (gap_q != HOLD_FULL) gap_q <= gap_q + 1'b1;
  end

  // R7: updates are spaced by at least the hold-off interval
  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_q) |-> (gap_q >= HOLD_FULL));

  // R4: at most one register flag per cycle
  a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_q));

  // R4: register contents move only together with a flag
  a_r4_flagged_change: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_q != $past(regs_q)) |-> (|upd_q));

  // R5: a word with the reserved bit set leaves the pending values alone
  a_r5_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && word_i[0]) |=> $stable(pval_q));

  // R8: nothing is applied while the interval is still running
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q != '0) |=> (upd_q == '0));

endmodule

// File: rtl/strobe_ctl_loader.sv
module strobe_ctl_loader #(
  parameter int WORD_W       = 16,
  parameter int NUM_REGS     = 4,
  parameter int ADDR_LSB     = 1,
  parameter int EXTRA_PULSES = 4,
  parameter int HOLDOFF_CYC  = 15625
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_strobe_i,
  input  logic                       ctl_drdy_i,
  input  logic                       ctl_data_i,
  output logic [NUM_REGS*WORD_W-1:0] regs_o,
  output logic [NUM_REGS-1:0]        upd_o
);

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word;
  logic              commit;

  ctl_pin_sync #(
    .WIDTH  (3),
    .STAGES (2),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_s_q),
    .pin_i ({ctl_strobe_i, ctl_drdy_i, ctl_data_i}),
    .sync_o(pins_s)
  );

  ctl_frame_rx #(
    .WORD_W      (WORD_W),
    .EXTRA_PULSES(EXTRA_PULSES)
  ) u_rx (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .strobe_s(pins_s[2]),
    .drdy_s  (pins_s[1]),
    .data_s  (pins_s[0]),
    .word_o  (word),
    .commit_o(commit)
  );

  ctl_update_gate #(
    .WORD_W     (WORD_W),
    .NUM_REGS   (NUM_REGS),
    .ADDR_LSB   (ADDR_LSB),
    .HOLDOFF_CYC(HOLDOFF_CYC)
  ) u_gate (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .commit_i(commit),
    .word_i  (word),
    .regs_o  (regs_o),
    .upd_o   (upd_o)
  );

endmodule

// File: tb/test_strobe_ctl_loader.sv
`timescale 1ns/1ps
module test_strobe_ctl_loader;

  localparam int HOLD = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        drdy = 1'b1;
  logic        data = 1'b0;
  logic [63:0] regs;
  logic [3:0]  upd;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_upd = -100000;
  bit done = 0;

  int          q_addr[$];
  logic [15:0] q_val[$];
  logic [15:0] mdl[4];

  always #4 clk = ~clk;

  strobe_ctl_loader #(.HOLDOFF_CYC(HOLD)) i_strobe_ctl_loader (
    .clk(clk), .rst_n(rst_n), .ctl_strobe_i(strobe), .ctl_drdy_i(drdy),
    .ctl_data_i(data), .regs_o(regs), .upd_o(upd)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse(input int half);
    wait_cyc(half); strobe = 1'b1;
    wait_cyc(half); strobe = 1'b0;
  endtask

  // Driver: nb data bits (MSB first), then nx extra strobe pulses
  task automatic send(input logic [15:0] w, input int nb, input int nx, input int half);
    drdy = 1'b0;
    wait_cyc(4);
    for (int i = 0; i < nb; i++) begin
      data = (i < 16) ? w[15-i] : 1'b0;
      pulse(half);
    end
    wait_cyc(4);
    drdy = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < nx; i++) pulse(half);
    wait_cyc(6);
  endtask

  task automatic expect_upd(input int a, input logic [15:0] v);
    q_addr.push_back(a);
    q_val.push_back(v);
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 4; i++) check(req, regs[16*i +: 16], mdl[i]);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    cyc++;
    if (rst_n && upd != 4'b0) begin
      if (q_addr.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5/R6/R3: actual unexpected flag %b expected none", upd);
      end else begin
        int a;
        logic [15:0] v;
        a = q_addr.pop_front();
        v = q_val.pop_front();
        check("R4", upd, 4'b1 << a);
        check("R2", regs[16*a +: 16], v);
        check("R7", (cyc - last_upd) >= HOLD, 1);
        mdl[a] = v;
      end
      last_upd = cyc;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mdl[i] = 16'h0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    @(negedge clk);
    check("R1", regs, 64'h0);
    check("R1", upd, 4'h0);

    // R2/R4: register 0, immediate update
    expect_upd(0, 16'h1230);
    send(16'h1230, 16, 4, 3);
    wait_cyc(1200);
    check_regs("R4");

    // R4: register 3, immediate; then three commits inside the interval (R8)
    expect_upd(3, 16'hABC6);
    send(16'hABC6, 16, 4, 3);
    expect_upd(1, 16'h0F02);
    expect_upd(2, 16'h7774);
    send(16'h5554, 16, 4, 3);
    send(16'h7774, 16, 4, 3);
    send(16'h0F02, 16, 4, 3);
    @(negedge clk);
    check("R8", regs[16 +: 16], 16'h0);
    wait_cyc(2600);
    check("R8", q_addr.size(), 0);
    check_regs("R8");

    // R5: reserved bit set
    send(16'h1231, 16, 4, 3);
    wait_cyc(1200);
    check_regs("R5");

    // R6: short and long frames
    send(16'hFFF8, 15, 4, 3);
    wait_cyc(300);
    check_regs("R6");
    send(16'hFFF8, 17, 4, 3);
    wait_cyc(300);
    check_regs("R6");

    // R3: only three extra pulses, long pause, then the fourth
    send(16'hC3C4, 16, 3, 3);
    wait_cyc(3000);
    check_regs("R3");
    expect_upd(2, 16'hC3C4);
    pulse(3);
    wait_cyc(1200);
    check("R3", q_addr.size(), 0);
    check_regs("R3");

    // R9: very slow strobe
    expect_upd(1, 16'h2222);
    send(16'h2222, 16, 4, 50);
    wait_cyc(1200);
    check("R9", q_addr.size(), 0);
    check_regs("R9");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule